// File: doc/BRIEF.md
# Lock-Gated Sync Pulse Generator

This block issues one synchronisation pulse per software request. A register-style write port fills a set of staged configuration bytes: a divider value of `DIV_W` bits, an arm bit, an output inversion bit and a two-bit mode field. A separate commit strobe copies the staged set into the working set. Once the working set is armed in single-shot mode, the block waits for the PLL lock indicator and then drives one pulse. The pulse is (divider + 1) clock cycles wide. The clock `clk` runs at twice the phase-detector rate, so one cycle is one half period of that rate.

The arm bit clears itself in both the staged and the working copy when the pulse ends. Software must therefore write and commit the arm bit again for each new pulse. A commit that arrives during a pulse is discarded. The divider and polarity of a running pulse cannot be disturbed. The counter only runs while a pulse is being produced. The lock input passes through a configurable synchroniser before it is used.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, `sync_out` is 0 and stays 0 until a valid request is committed. All staged and working fields reset to 0.
- R2: The working set may hold mode single-shot (code 1), arm = 1 and synchronised lock = 1, with no pulse running. In that case exactly one pulse starts. It becomes visible after the first rising edge that follows the edge on which the commit strobe was sampled.
- R3: The pulse lasts divider+1 cycles of `clk`. The divider's low byte is written at address 0 and its high byte at address 1. The width is taken from the working divider when the pulse starts.
- R4: `pll_locked` is delayed by `LOCK_SYNC_STAGES` flops (2 by default). No pulse starts while the delayed lock is 0. An armed request stays pending and fires once the lock becomes 1.
- R5: When a pulse ends, the arm bit is cleared in the staged and working copies. A later commit with no new write of the arm bit produces no pulse.
- R6: Control byte (address 2) bit 1 is the inversion bit. The output idle level equals the committed inversion bit, and the pulse drives the opposite level.
- R7: Mode codes 0, 2 and 3 (control bits 3:2) never start a pulse, even when arm (control bit 0) is 1.
- R8: A commit strobe during a pulse is discarded. The running pulse keeps its width and level. The staged arm bit is still cleared at the end of the pulse, so no second pulse follows.
- R9: Writes to the staged registers without a commit leave `sync_out` unchanged.
- R10: A fall of the lock indicator during a pulse does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the phase-detector rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the staged registers |
| reg_addr | input | ADDR_W | Staged register address (divider bytes, then control) |
| reg_wdata | input | DATA_W | Write data |
| commit | input | 1 | Copies the staged set into the working set when idle |
| pll_locked | input | 1 | PLL lock indicator, asynchronous |
| sync_out | output | 1 | Sync pulse output |

## Verification
The bench goes after the width boundaries: divider 0 must give a single-cycle pulse, and a divider with a non-zero high byte catches a design that ignores or swaps the upper byte. It holds an armed request with lock low to expose a design that fires early or drops the request. It also drops the lock mid-pulse to catch one that truncates the pulse. A commit issued in the middle of a pulse would, in a faulty design, restart or resize that pulse or leave a stale arm that fires a second one. A bare re-commit after a pulse reveals an arm bit that never clears.

// File: rtl/sync_pkg.sv
package sync_pkg;
   typedef enum logic [1:0] {
      SM_OFF    = 2'd0,
      SM_SINGLE = 2'd1,
      SM_RSV2   = 2'd2,
      SM_RSV3   = 2'd3
   } sync_mode_e;

   // control byte field positions
   localparam int CTRL_ARM_BIT  = 0;
   localparam int CTRL_INV_BIT  = 1;
   localparam int CTRL_MODE_LSB = 2;
   localparam int CTRL_MIN_W    = 4;
endpackage

// File: rtl/sync_lock_sync.sv
module sync_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign lock_out = lock_in;
      end else begin : g_chain
         logic [STAGES-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else if (STAGES == 1) stg <= lock_in;
            else stg <= {stg[STAGES-2:0], lock_in};
         end
         assign lock_out = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
   import sync_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              commit,
   input  logic              busy,
   input  logic              done,
   output logic [DIV_W-1:0]  div_act,
   output logic              inv_act,
   output sync_mode_e        mode_act,
   output logic              arm_act
);
   localparam int DIV_BYTES = DIV_W / DATA_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(DIV_BYTES);

   logic [DIV_W-1:0] div_sh;
   logic             arm_sh;
   logic             inv_sh;
   sync_mode_e       mode_sh;
   logic             ctrl_hit;
   logic             take;

   assign ctrl_hit = reg_we && (reg_addr == CTRL_ADDR);
   assign take     = commit && !busy;

   generate
      for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_sh[b*DATA_W +: DATA_W] <= '0;
            else if (reg_we && reg_addr == ADDR_W'(b))
               div_sh[b*DATA_W +: DATA_W] <= reg_wdata;
         end
      end
   endgenerate

   // staged control; end-of-pulse clear wins over a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_sh  <= 1'b0;
         inv_sh  <= 1'b0;
         mode_sh <= SM_OFF;
      end else begin
         if (ctrl_hit) begin
            arm_sh  <= reg_wdata[CTRL_ARM_BIT];
            inv_sh  <= reg_wdata[CTRL_INV_BIT];
            mode_sh <= sync_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
         end
         if (done) arm_sh <= 1'b0;
      end
   end

   // working set: only taken while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_act  <= '0;
         inv_act  <= 1'b0;
         mode_act <= SM_OFF;
         arm_act  <= 1'b0;
      end else if (take) begin
         div_act  <= div_sh;
         inv_act  <= inv_sh;
         mode_act <= mode_sh;
         arm_act  <= arm_sh;
      end else if (done) begin
         arm_act  <= 1'b0;
      end
   end
endmodule

// File: rtl/sync_width_ctr.sv
module sync_width_ctr #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] width_m1,
   output logic             busy,
   output logic             done,
   output logic [DIV_W-1:0] cnt
);
   // counter advances only while a pulse runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= width_m1;
      end
   end

   assign done = busy && (cnt == '0);
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
   import sync_pkg::*;
#(
   parameter int DIV_W            = 16,
   parameter int DATA_W           = 8,
   parameter int ADDR_W           = 2,
   parameter int LOCK_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              commit,
   input  logic              pll_locked,
   output logic              sync_out
);
   localparam int DIV_BYTES = DIV_W / DATA_W;

   generate
      if (DIV_W % DATA_W != 0) begin : g_bad_div
         $error("DIV_W must be a whole number of DATA_W bytes");
      end
      if (DATA_W < CTRL_MIN_W) begin : g_bad_data
         $error("DATA_W too narrow for the control fields");
      end
      if ((1 << ADDR_W) <= DIV_BYTES) begin : g_bad_addr
         $error("ADDR_W cannot reach the control register");
      end
      if (LOCK_SYNC_STAGES < 0) begin : g_bad_sync
         $error("LOCK_SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             lock_s;
   logic [DIV_W-1:0] div_act;
   logic             inv_act;
   sync_mode_e       mode_act;
   logic             arm_act;
   logic             busy;
   logic             done;
   logic [DIV_W-1:0] cnt;
   logic             start;

   sync_lock_sync #(.STAGES(LOCK_SYNC_STAGES)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (pll_locked),
      .lock_out (lock_s)
   );

   sync_cfg_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .commit    (commit),
      .busy      (busy),
      .done      (done),
      .div_act   (div_act),
      .inv_act   (inv_act),
      .mode_act  (mode_act),
      .arm_act   (arm_act)
   );

   assign start = arm_act && (mode_act == SM_SINGLE) && lock_s && !busy;

   sync_width_ctr #(.DIV_W(DIV_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .width_m1 (div_act),
      .busy     (busy),
      .done     (done),
      .cnt      (cnt)
   );

   assign sync_out = busy ^ inv_act;
endmodule

// File: rtl/sync_pulse_chk.sv
module sync_pulse_chk #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic [DIV_W-1:0] cnt,
   input logic             arm_act,
   input logic [1:0]       mode_act,
   input logic             inv_act,
   input logic [DIV_W-1:0] div_act,
   input logic             lock_s,
   input logic             sync_out
);
   AST_START_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(lock_s) && $past(arm_act)); // R4

   AST_START_NEEDS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mode_act) == 2'd1); // R7

   AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cnt == $past(div_act)); // R3

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy && (cnt == $past(cnt) - 1'b1)); // R3

   AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !arm_act); // R5

   AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sync_out)); // R8

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(div_act) && $stable(inv_act)); // R8
endmodule

bind sync_pulse_gen sync_pulse_chk #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .cnt      (cnt),
   .arm_act  (arm_act),
   .mode_act (mode_act),
   .inv_act  (inv_act),
   .div_act  (div_act),
   .lock_s   (lock_s),
   .sync_out (sync_out)
);

// File: tb/sim_sync_pulse_gen.sv
module sim_sync_pulse_gen;
   localparam int CLK_HALF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       commit = 1'b0;
   logic       pll_locked = 1'b1;
   logic       sync_out;

   int    checks = 0;
   int    failures = 0;
   bit    fin = 1'b0;
   string cur_req = "R1";

   always #CLK_HALF clk = ~clk;

   sync_pulse_gen u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .commit(commit), .pll_locked(pll_locked),
      .sync_out(sync_out)
   );

   // behavioural reference
   int s_div, a_div, rem;
   bit s_arm, s_inv, a_arm, a_inv, q1, q2, exp_out;
   int s_mode, a_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         s_div = 0; a_div = 0; rem = 0; s_arm = 0; s_inv = 0; s_mode = 0;
         a_arm = 0; a_inv = 0; a_mode = 0; q1 = 0; q2 = 0;
      end else begin
         bit lk, bz, st;
         int st_div;
         lk = q2; q2 = q1; q1 = pll_locked;
         bz = (rem > 0);
         st = !bz && a_arm && (a_mode == 1) && lk;
         st_div = a_div;
         if (commit && !bz) begin
            a_div = s_div; a_arm = s_arm; a_inv = s_inv; a_mode = s_mode;
         end
         if (reg_we) begin
            case (reg_addr)
               2'd0: s_div = (s_div & 32'hFF00) | reg_wdata;
               2'd1: s_div = (s_div & 32'h00FF) | (int'(reg_wdata) << 8);
               2'd2: begin
                  s_arm = reg_wdata[0]; s_inv = reg_wdata[1];
                  s_mode = reg_wdata[3:2];
               end
               default: ;
            endcase
         end
         if (bz) begin
            rem = rem - 1;
            if (rem == 0) begin s_arm = 0; a_arm = 0; end
         end else if (st) begin
            rem = st_div + 1;
         end
      end
      exp_out = (rem > 0) ^ a_inv;
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         checks++;
         if (sync_out !== exp_out) begin
            failures++;
            $display("FAIL %s cycle compare: actual=%0b expected=%0b", cur_req, sync_out, exp_out);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic do_commit();
      @(negedge clk); commit = 1'b1;
      @(negedge clk); commit = 1'b0;
   endtask

   task automatic set_div(input int v);
      wr(2'd0, v[7:0]);
      wr(2'd1, v[15:8]);
   endtask

   // watch n cycles; act 1: drop lock at cycle k; act 2: stage arm, divider, commit from cycle k
   task automatic watch(input int n, input bit idle, input int act, input int k,
                        output int pulses, output int width);
      bit prev;
      prev = 1'b0; pulses = 0; width = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         reg_we = 1'b0; commit = 1'b0;
         if (act == 1 && i == k) pll_locked = 1'b0;
         if (act == 2 && i == k)     begin reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h05; end
         if (act == 2 && i == k + 1) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h03; end
         if (act == 2 && i == k + 2) commit = 1'b1;
         if (sync_out != idle) begin
            width++;
            if (!prev) pulses++;
         end
         prev = (sync_out != idle);
      end
      @(negedge clk); reg_we = 1'b0; commit = 1'b0;
   endtask

   initial begin
      #(CLK_HALF * 2 * 200000);
      failures++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      fin = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int p, w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      chk(sync_out == 1'b0, "R1", "reset level", sync_out, 0);
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R1", "pulses after reset", p, 0);

      cur_req = "R2";
      set_div(0); wr(2'd2, 8'h05); do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 1, "R2", "pulse count", p, 1);
      chk(w == 1, "R3", "width divider 0", w, 1);

      cur_req = "R5";
      do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R5", "re-commit without arm", p, 0);

      cur_req = "R3";
      set_div(5); wr(2'd2, 8'h05); do_commit();
      watch(15, 0, 0, 0, p, w);
      chk(w == 6, "R3", "width divider 5", w, 6);
      set_div(16'h0102); wr(2'd2, 8'h05); do_commit();
      watch(270, 0, 0, 0, p, w);
      chk(w == 259, "R3", "width divider 0x0102", w, 259);

      cur_req = "R9";
      wr(2'd2, 8'h07); set_div(2);
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R9", "staged writes only", p, 0);

      cur_req = "R6";
      wr(2'd2, 8'h06); do_commit();
      watch(5, 1, 0, 0, p, w);
      chk(sync_out == 1'b1, "R6", "inverted idle level", sync_out, 1);
      chk(p == 0, "R6", "pulses when unarmed", p, 0);
      wr(2'd2, 8'h07); do_commit();
      watch(10, 1, 0, 0, p, w);
      chk(p == 1 && w == 3, "R6", "inverted pulse width", w, 3);

      cur_req = "R7";
      wr(2'd2, 8'h01); do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R7", "mode 0 armed", p, 0);
      wr(2'd2, 8'h0D); do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R7", "mode 3 armed", p, 0);
      wr(2'd2, 8'h09); do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R7", "mode 2 armed", p, 0);

      cur_req = "R4";
      wr(2'd2, 8'h00); do_commit();
      @(negedge clk); pll_locked = 1'b0;
      set_div(4); wr(2'd2, 8'h05); do_commit();
      watch(20, 0, 0, 0, p, w);
      chk(p == 0, "R4", "pulses while unlocked", p, 0);
      @(negedge clk); pll_locked = 1'b1;
      watch(15, 0, 0, 0, p, w);
      chk(p == 1 && w == 5, "R4", "pending request width", w, 5);

      cur_req = "R8";
      set_div(20); wr(2'd2, 8'h05); do_commit();
      watch(60, 0, 2, 6, p, w);
      chk(p == 1, "R8", "pulse count with mid commit", p, 1);
      chk(w == 21, "R8", "width with mid commit", w, 21);
      do_commit();
      watch(10, 0, 0, 0, p, w);
      chk(p == 0, "R8", "stale arm after pulse", p, 0);

      cur_req = "R10";
      set_div(10); wr(2'd2, 8'h05); do_commit();
      watch(25, 0, 1, 4, p, w);
      chk(p == 1 && w == 11, "R10", "width with lock drop", w, 11);
      pll_locked = 1'b1;

      fin = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule